// File: doc/BRIEF.md
# Half-Bridge PWM Timer with Dead-Time Insertion

This block is a 12-bit up-counting pulse-width timer that drives the two gates of a half bridge. A duty compare value picks which leg is wanted: the high leg while the count is below it, and the low leg from there to the end of the period. Polarity can be swapped. Before a leg is switched on, a state machine holds both legs off for a programmable number of timer clocks, so the two gates can never conduct together. A second compare value raises a one-cycle strobe that can start an ADC conversion at a chosen point of each period. A shutdown input forces both gates off at once.

Software loads four configuration values through a simple write port. The duty, strobe and dead-time values act at once. The polarity bit is double-buffered and only changes the output at the next period boundary. The period wrap sets a sticky pending flag. In the alternate capture mode the gates stay off and the counter runs freely over its full range. The count is copied into the reload register on the selected edge of the capture pin, where software reads it back.

The dead-time machine has five states. OFF has both legs low. LEG_A and LEG_B each drive one leg high. GAP_A and GAP_B have both legs low while the machine counts down before it enters LEG_A or LEG_B. Its transitions are:
- activate: OFF to GAP_x, or straight to LEG_x when the dead time is zero.
- swap: LEG_A to GAP_B, or LEG_B to GAP_A, when the wanted leg changes. It goes straight to the other leg when the dead time is zero.
- expire: GAP_x to LEG_x when the gap count reaches zero.
- abandon: GAP_x to the other LEG when the wanted leg flips back during the gap.
- halt: any state to OFF when the timer is stopped, in capture mode or shut down.

Top module: `halfbridge_pwm`

## Requirements
- R1: After reset, the duty, strobe and reload registers hold 0xFFF and the dead time holds 0x1F. The count is 0, the pending flag and the strobe are low, both gates are low and the polarity readback is 0.
- R2: While the run input is low, the count is held at 0. Once run is high in PWM mode, the count steps by one per clock from 0. After the clock in which it equals the reload value (or 0xFFF), it returns to 0.
- R3: A wrap sets the pending flag. The flag stays set until a clear request. A wrap in the same cycle as a clear leaves the flag set.
- R4: With the active polarity at 0, the high leg (hs_a) is wanted while count < duty, and the low leg (hs_b) otherwise. An active polarity of 1 swaps the two legs.
- R5: A leg turns on only after the dead time N (in timer clocks) with both legs low. N = 0 hands over directly. If the wanted leg flips back during a gap, the machine returns to that leg.
- R6: hs_a and hs_b are never high in the same cycle.
- R7: A polarity write changes attr_rd on the next clock. The outputs follow it only after the next wrap, or at once while run is low.
- R8: adc_strobe is high for exactly the clock after a PWM-mode clock in which the count equals the strobe value.
- R9: In capture mode, both gates stay low and the count runs over its full 12-bit range, setting pending at the wrap. A rising edge of cap_in (capture_fall = 0) or a falling edge (capture_fall = 1) loads the count of the detecting clock into the reload register.
- R10: While shutdown is high, both gates are low in that same cycle. Once shutdown is released, the machine re-enters a leg through a gap.
- R11: A write with cfg_we selects its target by cfg_sel: 0 duty, 1 strobe, 2 reload, 3 dead time (cfg_wdata[4:0]). The value takes effect on the next clock, and reload_o reads back the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 duty, 1 strobe, 2 reload, 3 dead time |
| cfg_wdata | input | 12 | Write data |
| attr_we | input | 1 | Polarity bit write strobe |
| attr_din | input | 1 | Polarity bit value |
| run_en | input | 1 | Timer enable |
| capture_mode | input | 1 | 1 selects input-capture mode |
| capture_fall | input | 1 | 1 captures on the falling edge, 0 on the rising edge |
| pend_clr | input | 1 | Clears the pending flag |
| shutdown | input | 1 | Forces both gates low |
| cap_in | input | 1 | Capture pin |
| hs_a | output | 1 | High-leg gate drive |
| hs_b | output | 1 | Low-leg gate drive |
| adc_strobe | output | 1 | ADC start pulse |
| pend | output | 1 | Sticky wrap flag |
| count_o | output | 12 | Current count |
| reload_o | output | 12 | Reload register readback |
| attr_rd | output | 1 | Last written polarity bit |

## Verification
The bench builds the block with its default widths: a 12-bit count and a 5-bit dead time. This lets one capture run pass the 0xFFF to 0 wrap within a few thousand clocks. Random PWM runs use short reload values (0 to 40) and dead times from 0 to 7. Every leg swap, the direct handover at zero dead time, the abandoned gap and the shutdown recovery therefore recur many times in each period. Directed runs cover a zero duty, a duty above the reload value, a reload of 0 and capture on both edge polarities.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_LEG_A = 3'd1,
        ST_GAP_B = 3'd2,
        ST_LEG_B = 3'd3,
        ST_GAP_A = 3'd4
    } leg_state_e;

    localparam logic [1:0] SEL_DUTY   = 2'd0;
    localparam logic [1:0] SEL_STROBE = 2'd1;
    localparam logic [1:0] SEL_RELOAD = 2'd2;
    localparam logic [1:0] SEL_DEAD   = 2'd3;
endpackage

// File: rtl/hbpwm_regs.sv
module hbpwm_regs
    import hbpwm_pkg::*;
#(
    parameter int CW = 12,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          cap_fire,
    input  logic [CW-1:0] cap_value,
    input  logic          attr_we,
    input  logic          attr_din,
    output logic [CW-1:0] duty_q,
    output logic [CW-1:0] strb_q,
    output logic [CW-1:0] per_q,
    output logic [DW-1:0] dead_q,
    output logic          attr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '1;
            strb_q <= '1;
            per_q  <= '1;
            dead_q <= '1;
            attr_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                unique case (cfg_sel)
                    SEL_DUTY:   duty_q <= cfg_wdata;
                    SEL_STROBE: strb_q <= cfg_wdata;
                    SEL_RELOAD: per_q  <= cfg_wdata;
                    SEL_DEAD:   dead_q <= cfg_wdata[DW-1:0];
                endcase
            end
            // a capture event has priority over a software reload write
            if (cap_fire) per_q <= cap_value;
            if (attr_we)  attr_q <= attr_din;
        end
    end
endmodule

// File: rtl/hbpwm_counter.sv
module hbpwm_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          capture_mode,
    input  logic          capture_fall,
    input  logic          cap_in,
    input  logic          pend_clr,
    input  logic [CW-1:0] per_q,
    input  logic [CW-1:0] strb_q,
    input  logic          attr_q,
    output logic [CW-1:0] cnt_q,
    output logic          pend_q,
    output logic          strobe_q,
    output logic          cap_fire,
    output logic          attr_act
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] limit;
    logic          wrap;
    logic          cap_d;

    assign limit    = capture_mode ? CNT_MAX : per_q;
    assign wrap     = run_en && ((cnt_q == limit) || (cnt_q == CNT_MAX));
    assign cap_fire = run_en && capture_mode &&
                      (capture_fall ? (cap_d && !cap_in) : (!cap_d && cap_in));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            strobe_q <= 1'b0;
            cap_d    <= 1'b0;
            attr_act <= 1'b0;
        end else begin
            cap_d    <= cap_in;
            strobe_q <= run_en && !capture_mode && (cnt_q == strb_q);
            if (!run_en)   cnt_q <= '0;
            else if (wrap) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
            if (wrap)          pend_q <= 1'b1;
            else if (pend_clr) pend_q <= 1'b0;
            if (!run_en || wrap) attr_act <= attr_q;
        end
    end
endmodule

// File: rtl/hbpwm_deadband.sv
module hbpwm_deadband
    import hbpwm_pkg::*;
#(
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          want_a,
    input  logic          shutdown,
    input  logic [DW-1:0] dead,
    output logic          hs_a,
    output logic          hs_b
);
    leg_state_e    st_q, st_d;
    logic [DW-1:0] gap_q, gap_d;
    logic          no_gap;
    logic [DW-1:0] gap_load;

    assign no_gap   = (dead == '0);
    assign gap_load = dead - 1'b1;

    always_comb begin
        st_d  = st_q;
        gap_d = gap_q;
        if (!active) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (want_a) st_d = no_gap ? ST_LEG_A : ST_GAP_A;
                    else        st_d = no_gap ? ST_LEG_B : ST_GAP_B;
                    gap_d = gap_load;
                end
                ST_LEG_A: if (!want_a) begin
                    st_d  = no_gap ? ST_LEG_B : ST_GAP_B;
                    gap_d = gap_load;
                end
                ST_LEG_B: if (want_a) begin
                    st_d  = no_gap ? ST_LEG_A : ST_GAP_A;
                    gap_d = gap_load;
                end
                ST_GAP_B: begin
                    if (want_a)           st_d = ST_LEG_A;
                    else if (gap_q == '0) st_d = ST_LEG_B;
                    else                  gap_d = gap_q - 1'b1;
                end
                ST_GAP_A: begin
                    if (!want_a)          st_d = ST_LEG_B;
                    else if (gap_q == '0) st_d = ST_LEG_A;
                    else                  gap_d = gap_q - 1'b1;
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            gap_q <= '0;
        end else begin
            st_q  <= st_d;
            gap_q <= gap_d;
        end
    end

    always_comb begin
        hs_a = (st_q == ST_LEG_A) && !shutdown;
        hs_b = (st_q == ST_LEG_B) && !shutdown;
    end
endmodule

// File: rtl/halfbridge_pwm.sv
module halfbridge_pwm #(
    parameter int CW = 12,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          attr_we,
    input  logic          attr_din,
    input  logic          run_en,
    input  logic          capture_mode,
    input  logic          capture_fall,
    input  logic          pend_clr,
    input  logic          shutdown,
    input  logic          cap_in,
    output logic          hs_a,
    output logic          hs_b,
    output logic          adc_strobe,
    output logic          pend,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] reload_o,
    output logic          attr_rd
);
    logic [CW-1:0] duty_q, strb_q, per_q;
    logic [DW-1:0] dead_q;
    logic          attr_q, attr_act, cap_fire, want_a, active;

    hbpwm_regs #(.CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cap_fire(cap_fire), .cap_value(count_o),
        .attr_we(attr_we), .attr_din(attr_din), .duty_q(duty_q),
        .strb_q(strb_q), .per_q(per_q), .dead_q(dead_q), .attr_q(attr_q)
    );

    hbpwm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .capture_mode(capture_mode), .capture_fall(capture_fall),
        .cap_in(cap_in), .pend_clr(pend_clr), .per_q(per_q),
        .strb_q(strb_q), .attr_q(attr_q), .cnt_q(count_o), .pend_q(pend),
        .strobe_q(adc_strobe), .cap_fire(cap_fire), .attr_act(attr_act)
    );

    assign want_a = (count_o < duty_q) ^ attr_act;
    assign active = run_en && !capture_mode && !shutdown;

    hbpwm_deadband #(.DW(DW)) u_db (
        .clk(clk), .rst_n(rst_n), .active(active), .want_a(want_a),
        .shutdown(shutdown), .dead(dead_q), .hs_a(hs_a), .hs_b(hs_b)
    );

    assign reload_o = per_q;
    assign attr_rd  = attr_q;
endmodule

// File: rtl/halfbridge_pwm_chk.sv
module halfbridge_pwm_chk #(
    parameter int CW = 12,
    parameter int DW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          pend_clr,
    input logic          shutdown,
    input logic          hs_a,
    input logic          hs_b,
    input logic          pend,
    input logic          adc_strobe,
    input logic [CW-1:0] count_o,
    input logic [CW-1:0] strb_q,
    input logic [DW-1:0] dead_q
);
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a && hs_b));

    p_shutdown_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!hs_a && !hs_b));

    p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);

    p_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (count_o == '0));

    p_strobe_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |-> ($past(run_en) && ($past(count_o) == $past(strb_q))));

    p_gap_before_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_a) && ($past(dead_q) != '0)) |-> !$past(hs_b));

    p_gap_before_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_b) && ($past(dead_q) != '0)) |-> !$past(hs_a));
endmodule

bind halfbridge_pwm halfbridge_pwm_chk #(.CW(CW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pend_clr(pend_clr),
    .shutdown(shutdown), .hs_a(hs_a), .hs_b(hs_b), .pend(pend),
    .adc_strobe(adc_strobe), .count_o(count_o), .strb_q(strb_q),
    .dead_q(dead_q)
);

// File: tb/tb_halfbridge_pwm.sv
`timescale 1ns/1ps
module tb_halfbridge_pwm;
    localparam int CW = 12;
    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          attr_we = 1'b0, attr_din = 1'b0;
    logic          run_en = 1'b0, capture_mode = 1'b0, capture_fall = 1'b0;
    logic          pend_clr = 1'b0, shutdown = 1'b0, cap_in = 1'b0;
    logic          hs_a, hs_b, adc_strobe, pend, attr_rd;
    logic [CW-1:0] count_o, reload_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    halfbridge_pwm #(.CW(CW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .attr_we(attr_we), .attr_din(attr_din),
        .run_en(run_en), .capture_mode(capture_mode),
        .capture_fall(capture_fall), .pend_clr(pend_clr),
        .shutdown(shutdown), .cap_in(cap_in), .hs_a(hs_a), .hs_b(hs_b),
        .adc_strobe(adc_strobe), .pend(pend), .count_o(count_o),
        .reload_o(reload_o), .attr_rd(attr_rd)
    );

    // reference model state, written from the requirements
    logic [CW-1:0] m_cnt, m_duty, m_strb, m_per;
    logic [DW-1:0] m_dead, m_gap;
    logic          m_pend, m_attr_q, m_attr_act, m_strobe, m_capd;
    int            m_st; // 0 off, 1 leg A, 2 gap to B, 3 leg B, 4 gap to A

    function automatic void model_init();
        m_cnt = '0; m_duty = '1; m_strb = '1; m_per = '1; m_dead = '1;
        m_gap = '0; m_pend = 0; m_attr_q = 0; m_attr_act = 0;
        m_strobe = 0; m_capd = 0; m_st = 0;
    endfunction

    function automatic void model_step();
        logic [CW-1:0] lim;
        logic wrap, want, act, fire;
        int ns;
        logic [DW-1:0] ng;
        lim  = capture_mode ? '1 : m_per;
        wrap = run_en && (m_cnt == lim || m_cnt == '1);
        want = (m_cnt < m_duty) ^ m_attr_act;
        act  = run_en && !capture_mode && !shutdown;
        fire = run_en && capture_mode &&
               (capture_fall ? (m_capd && !cap_in) : (!m_capd && cap_in));
        ns = m_st; ng = m_gap;
        if (!act) ns = 0;
        else case (m_st)
            0: begin
                if (want) ns = (m_dead == 0) ? 1 : 4;
                else      ns = (m_dead == 0) ? 3 : 2;
                ng = m_dead - 1'b1;
            end
            1: if (!want) begin ns = (m_dead == 0) ? 3 : 2; ng = m_dead - 1'b1; end
            3: if (want)  begin ns = (m_dead == 0) ? 1 : 4; ng = m_dead - 1'b1; end
            2: if (want) ns = 1; else if (m_gap == 0) ns = 3; else ng = m_gap - 1'b1;
            4: if (!want) ns = 3; else if (m_gap == 0) ns = 1; else ng = m_gap - 1'b1;
            default: ns = 0;
        endcase
        m_strobe = run_en && !capture_mode && (m_cnt == m_strb);
        if (!run_en || wrap) m_attr_act = m_attr_q;
        if (wrap) m_pend = 1; else if (pend_clr) m_pend = 0;
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: m_duty = cfg_wdata;
                2'd1: m_strb = cfg_wdata;
                2'd2: m_per  = cfg_wdata;
                default: m_dead = cfg_wdata[DW-1:0];
            endcase
        end
        if (fire) m_per = m_cnt;
        if (attr_we) m_attr_q = attr_din;
        m_capd = cap_in;
        m_cnt = (!run_en || wrap) ? '0 : m_cnt + 1'b1;
        m_st = ns; m_gap = ng;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic ea, eb;
        ea = (m_st == 1) && !shutdown;
        eb = (m_st == 3) && !shutdown;
        check(count_o == m_cnt, "R2 count", count_o, m_cnt);
        check(pend == m_pend, "R3 pending", pend, m_pend);
        check(hs_a == ea, "R4 R5 R10 hs_a", hs_a, ea);
        check(hs_b == eb, "R4 R5 R10 hs_b", hs_b, eb);
        check(!(hs_a && hs_b), "R6 overlap", {hs_a, hs_b}, 0);
        check(adc_strobe == m_strobe, "R8 strobe", adc_strobe, m_strobe);
        check(reload_o == m_per, "R9 R11 reload", reload_o, m_per);
        check(attr_rd == m_attr_q, "R7 readback", attr_rd, m_attr_q);
        if (capture_mode) check(!hs_a && !hs_b, "R9 gates low", {hs_a, hs_b}, 0);
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [CW-1:0] val);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        step();
        cfg_we = 0;
    endtask

    task automatic pwm_run(input logic [CW-1:0] duty, input logic [CW-1:0] per,
                           input logic [CW-1:0] strb, input logic [DW-1:0] dead,
                           input int cycles, input bit use_sd);
        run_en = 0; capture_mode = 0;
        step();
        wr(2'd0, duty); wr(2'd2, per); wr(2'd1, strb); wr(2'd3, dead);
        run_en = 1;
        for (int i = 0; i < cycles; i++) begin
            pend_clr = ($urandom_range(7) == 0);
            attr_we  = ($urandom_range(29) == 0);
            attr_din = $urandom_range(1);
            shutdown = use_sd && ($urandom_range(24) == 0);
            step();
        end
        pend_clr = 0; attr_we = 0; shutdown = 0;
    endtask

    task automatic cap_run(input bit fall, input int cycles);
        run_en = 0;
        step();
        capture_mode = 1; capture_fall = fall; run_en = 1;
        for (int i = 0; i < cycles; i++) begin
            if ($urandom_range(9) == 0) cap_in = ~cap_in;
            pend_clr = ($urandom_range(63) == 0);
            step();
        end
        pend_clr = 0; run_en = 0;
        step();
        capture_mode = 0; cap_in = 0;
        step();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        model_init();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(reload_o == 12'hFFF, "R1 reload reset", reload_o, 12'hFFF);
        check(count_o == 0, "R1 count reset", count_o, 0);
        check(!pend && !adc_strobe, "R1 flags reset", {pend, adc_strobe}, 0);
        check(!hs_a && !hs_b, "R1 gates reset", {hs_a, hs_b}, 0);
        check(attr_rd == 0, "R1 polarity reset", attr_rd, 0);
        // R1 reset registers in use: duty 0xFFF keeps leg A wanted after dead 0x1F
        run_en = 1;
        for (int i = 0; i < 40; i++) step();
        check(hs_a == 1, "R1 R4 default duty", hs_a, 1);
        // directed corners
        pwm_run(12'd0,  12'd9,  12'd3, 5'd0, 60, 0);  // zero duty, zero dead
        pwm_run(12'd50, 12'd20, 12'd20, 5'd3, 80, 0); // duty above reload
        pwm_run(12'd0,  12'd0,  12'd0, 5'd2, 30, 0);  // reload 0
        pwm_run(12'd5,  12'd12, 12'd7, 5'd4, 200, 1); // shutdown pulses
        // random PWM scenarios
        for (int s = 0; s < 14; s++) begin
            logic [CW-1:0] per;
            per = $urandom_range(40);
            pwm_run($urandom_range(per + 2), per, $urandom_range(per + 1),
                    $urandom_range(7), 180, (s % 3) == 0);
        end
        // capture mode on both edges, one run long enough to pass the wrap
        cap_run(1'b0, 400);
        cap_run(1'b1, 4300);
        pwm_run(12'd6, 12'd15, 12'd2, 5'd1, 100, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule